// File: doc/BRIEF.md
# I2C Addressed-Memory Transaction Sequencer

This block turns one request into a complete I2C transaction: a presence probe, an addressed read, or an addressed write. It sits above a bit-level master engine and sends that engine one command at a time: START, STOP, write a byte, or read a byte. After each command it waits for the engine's single completion response. A request gives the 7-bit chip address, a sub-address of 0 to 4 bytes with its value, and a byte count. Bytes to write come in on a byte stream, and bytes that are read go out on another.

Address-phase failures end the transaction. They are a NACK on the chip address, on any sub-address byte, or on the read-direction chip address. In each case the block issues STOP and reports an error. On a write, a NACK on a data byte only adds to a failure count, and the transfer goes on. A configuration input chooses how a read turns around between its address phase and its data phase. An optional folding mode moves sub-address bits that do not fit the sub-address width into the low chip-address bits. This serves memories that spread their upper address bits over several device addresses.

Every transaction ends with a one-cycle done pulse. The pulse carries an error flag and the count of failed data bytes.

Top module: `i2c_xact_seq`

## Requirements
- R1: Request kind 0 is a probe. It issues START, then WRITE of {chip,0}, then STOP. done_err equals the NACK received on that byte, so 0 means the device is present. Engine command codes are START=0, STOP=1, WRITE=2 and READ=3. Request kinds are probe=0, read=1 and write=2.
- R2: Sub-address bytes are sent as WRITE commands, most-significant byte first. The number of bytes sent equals req_alen.
- R3: A read with req_alen greater than 0 starts with START, WRITE {chip,0}, and then the sub-address bytes. If the {chip,0} byte is NACKed, the next command is STOP and done_err is 1.
- R4: A NACK on any sub-address byte, in a read or a write, stops further address and data bytes. The next command is STOP, done_err is 1 and done_fails is 0.
- R5: Between the sub-address and the read-direction address, the block sends STOP then START when cfg_rep_start is 0, and START alone when it is 1.
- R6: A read with req_alen equal to 0 sends START and then WRITE {chip,1} directly, with no write-direction phase.
- R7: A read of N bytes issues N READ commands. The NACK flag is 0 on every one except the last, where it is 1. The read bytes appear on rd_tdata in order, and a STOP follows. rd_tdata holds steady while rd_tready is low.
- R8: When cfg_fold_en is 1 and the request is a read or a write, the chip address used is chip | ((addr >> 8*alen) & cfg_fold_mask). The term is 0 when alen is 4. The sub-address bytes and their count are unchanged. The chip address is never changed when cfg_fold_en is 0 or for a probe.
- R9: On a write, each of the req_len bytes from the write stream is sent as a WRITE. A NACK on a data byte adds one to done_fails and does not stop the transfer. A STOP ends the transaction, and done_err is 0.
- R10: If the read-direction {chip,1} byte is NACKed, no READ is issued. STOP follows, done_err is 1 and no byte appears on rd_tdata.
- R11: req_ready is high only while idle. An offered engine command holds its code and byte until eng_cmd_ready. After reset, req_ready is 1 and eng_cmd_valid, rd_tvalid and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted (idle) |
| req_kind | input | 2 | 0 probe, 1 read, 2 write |
| req_chip | input | 7 | Chip address |
| req_alen | input | 3 | Sub-address width in bytes (0..4) |
| req_addr | input | 32 | Sub-address value |
| req_len | input | 16 | Data byte count |
| cfg_rep_start | input | 1 | 1: repeated START turnaround; 0: STOP then START |
| cfg_fold_en | input | 1 | Enable address-overflow folding |
| cfg_fold_mask | input | 7 | Chip bits that folding may set |
| wr_tvalid | input | 1 | Write byte available |
| wr_tready | output | 1 | Write byte taken |
| wr_tdata | input | 8 | Write byte |
| rd_tvalid | output | 1 | Read byte available |
| rd_tready | input | 1 | Read byte taken |
| rd_tdata | output | 8 | Read byte |
| eng_cmd_valid | output | 1 | Engine command offered |
| eng_cmd_ready | input | 1 | Engine accepts command |
| eng_cmd_op | output | 2 | Engine command code |
| eng_cmd_byte | output | 8 | Byte to write |
| eng_cmd_nack | output | 1 | For READ: answer with NACK |
| eng_rsp_valid | input | 1 | Engine command complete |
| eng_rsp_nack | input | 1 | For WRITE: byte was NACKed |
| eng_rsp_byte | input | 8 | For READ: byte received |
| done | output | 1 | One-cycle end-of-transaction pulse |
| done_err | output | 1 | Address phase failed (or probe absent) |
| done_fails | output | 16 | Write data bytes NACKed |

## Verification
The hardest cases to reach from the ports are the aborts in the middle of an address phase. Examples are a NACK on the second of three sub-address bytes, or a NACK on the read-direction address after a full write-direction phase. Write-data NACKs spread among good bytes are equally hard. The bench's engine model answers each WRITE command according to a per-transaction NACK mask, indexed by the WRITE's position in the transaction. This puts a failure on any chosen byte. Each complete command stream is compared against a sequence the bench builds from the requirements. The read stream is also throttled every other cycle, so the data hold under back-pressure is exercised.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } eng_op_e;

  localparam logic [1:0] KIND_PROBE = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;
  localparam logic [1:0] KIND_WRITE = 2'd2;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_START,
    PH_CHIPW,
    PH_SUB,
    PH_TSTOP,
    PH_START2,
    PH_CHIPR,
    PH_RDATA,
    PH_WDATA,
    PH_STOP,
    PH_DONE
  } seq_phase_e;

endpackage

// File: rtl/i2c_seq_fold.sv
module i2c_seq_fold #(
  parameter int ADDR_BYTES = 4,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int ALEN_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic [6:0]        chip_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ALEN_W-1:0] alen_i,
  input  logic [6:0]        mask_i,
  input  logic              en_i,
  output logic [6:0]        chip_o
);

  // Address bits left over above the sub-address width, moved to bit 0.
  function automatic logic [6:0] spill_bits(input logic [ADDR_W-1:0] a,
                                            input logic [ALEN_W-1:0] n);
    logic [ADDR_W-1:0] s;
    s = a;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (k < int'(n)) s = s >> 8;
    end
    return s[6:0];
  endfunction

  assign chip_o = en_i ? (chip_i | (spill_bits(addr_i, alen_i) & mask_i)) : chip_i;

endmodule

// File: rtl/i2c_seq_subaddr.sv
module i2c_seq_subaddr #(
  parameter int ADDR_BYTES = 4,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int ALEN_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ALEN_W-1:0] idx_i,
  output logic [7:0]        byte_o
);

  // Byte number idx of the sub-address, byte 0 being the least significant.
  function automatic logic [7:0] pick_byte(input logic [ADDR_W-1:0] a,
                                           input logic [ALEN_W-1:0] i);
    logic [ADDR_W-1:0] s;
    s = a;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (k < int'(i)) s = s >> 8;
    end
    return s[7:0];
  endfunction

  assign byte_o = pick_byte(addr_i, idx_i);

endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W = 16,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int ALEN_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [6:0]        req_chip_f,
  input  logic [ALEN_W-1:0] req_alen,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              cfg_rep_start,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ALEN_W-1:0] sub_idx,
  input  logic [7:0]        sub_byte,
  input  logic              wr_tvalid,
  output logic              wr_tready,
  input  logic [7:0]        wr_tdata,
  output logic              rd_tvalid,
  input  logic              rd_tready,
  output logic [7:0]        rd_tdata,
  output logic              eng_cmd_valid,
  input  logic              eng_cmd_ready,
  output logic [1:0]        eng_cmd_op,
  output logic [7:0]        eng_cmd_byte,
  output logic              eng_cmd_nack,
  input  logic              eng_rsp_valid,
  input  logic              eng_rsp_nack,
  input  logic [7:0]        eng_rsp_byte,
  output logic              done,
  output logic              done_err,
  output logic [LEN_W-1:0]  done_fails
);

  seq_phase_e        phase_q;
  logic              waiting_q, holding_q;
  logic [1:0]        kind_q;
  logic [6:0]        chip_q;
  logic [ALEN_W-1:0] alen_q, idx_q;
  logic [LEN_W-1:0]  len_q, rem_q, fails_q;
  logic              rep_q, err_q;
  logic [7:0]        rdbyte_q;

  // Named internal events
  logic    issue, cmd_fire, rsp_fire, rd_fire, req_fire;
  logic    addr_abort_evt, data_nack_evt, last_rem;
  eng_op_e op;

  assign req_ready = (phase_q == PH_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign last_rem  = (rem_q == LEN_W'(1));

  always_comb begin
    op           = OP_START;
    eng_cmd_byte = 8'h00;
    eng_cmd_nack = 1'b0;
    issue        = 1'b0;
    case (phase_q)
      PH_START, PH_START2: begin issue = 1'b1; op = OP_START; end
      PH_TSTOP, PH_STOP:   begin issue = 1'b1; op = OP_STOP; end
      PH_CHIPW: begin issue = 1'b1; op = OP_WRITE; eng_cmd_byte = {chip_q, 1'b0}; end
      PH_SUB:   begin issue = 1'b1; op = OP_WRITE; eng_cmd_byte = sub_byte; end
      PH_CHIPR: begin issue = 1'b1; op = OP_WRITE; eng_cmd_byte = {chip_q, 1'b1}; end
      PH_WDATA: begin issue = wr_tvalid; op = OP_WRITE; eng_cmd_byte = wr_tdata; end
      PH_RDATA: begin issue = 1'b1; op = OP_READ; eng_cmd_nack = last_rem; end
      default: ;
    endcase
  end

  assign eng_cmd_op    = op;
  assign eng_cmd_valid = issue && !waiting_q && !holding_q;
  assign cmd_fire      = eng_cmd_valid && eng_cmd_ready;
  assign wr_tready     = (phase_q == PH_WDATA) && !waiting_q && eng_cmd_ready;
  assign rsp_fire      = waiting_q && eng_rsp_valid;
  assign rd_tvalid     = holding_q;
  assign rd_tdata      = rdbyte_q;
  assign rd_fire       = holding_q && rd_tready;
  assign addr_abort_evt = rsp_fire && eng_rsp_nack &&
                          (phase_q == PH_CHIPW || phase_q == PH_SUB || phase_q == PH_CHIPR);
  assign data_nack_evt  = rsp_fire && eng_rsp_nack && (phase_q == PH_WDATA);

  assign sub_idx    = idx_q;
  assign done       = (phase_q == PH_DONE);
  assign done_err   = err_q;
  assign done_fails = fails_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      waiting_q <= 1'b0;
      holding_q <= 1'b0;
      kind_q    <= KIND_PROBE;
      chip_q    <= '0;
      alen_q    <= '0;
      idx_q     <= '0;
      addr_q    <= '0;
      len_q     <= '0;
      rem_q     <= '0;
      fails_q   <= '0;
      rep_q     <= 1'b0;
      err_q     <= 1'b0;
      rdbyte_q  <= '0;
    end else begin
      if (req_fire) begin
        kind_q  <= req_kind;
        chip_q  <= req_chip_f;
        alen_q  <= req_alen;
        addr_q  <= req_addr;
        len_q   <= req_len;
        rem_q   <= req_len;
        rep_q   <= cfg_rep_start;
        err_q   <= 1'b0;
        fails_q <= '0;
        phase_q <= PH_START;
      end
      if (cmd_fire) waiting_q <= 1'b1;
      if (rsp_fire) begin
        waiting_q <= 1'b0;
        case (phase_q)
          PH_START:
            phase_q <= (kind_q == KIND_READ && alen_q == '0) ? PH_CHIPR : PH_CHIPW;
          PH_CHIPW:
            if (eng_rsp_nack) begin
              err_q <= 1'b1; phase_q <= PH_STOP;
            end else if (kind_q == KIND_PROBE) begin
              phase_q <= PH_STOP;
            end else if (alen_q != '0) begin
              idx_q <= alen_q - ALEN_W'(1); phase_q <= PH_SUB;
            end else begin
              phase_q <= (len_q != '0) ? PH_WDATA : PH_STOP;
            end
          PH_SUB:
            if (eng_rsp_nack) begin
              err_q <= 1'b1; phase_q <= PH_STOP;
            end else if (idx_q != '0) begin
              idx_q <= idx_q - ALEN_W'(1);
            end else if (kind_q == KIND_READ) begin
              phase_q <= rep_q ? PH_START2 : PH_TSTOP;
            end else begin
              phase_q <= (len_q != '0) ? PH_WDATA : PH_STOP;
            end
          PH_TSTOP:  phase_q <= PH_START2;
          PH_START2: phase_q <= PH_CHIPR;
          PH_CHIPR:
            if (eng_rsp_nack) begin
              err_q <= 1'b1; phase_q <= PH_STOP;
            end else begin
              phase_q <= (len_q != '0) ? PH_RDATA : PH_STOP;
            end
          PH_RDATA: begin
            rdbyte_q  <= eng_rsp_byte;
            holding_q <= 1'b1;
          end
          PH_WDATA: begin
            if (eng_rsp_nack) fails_q <= fails_q + LEN_W'(1);
            rem_q <= rem_q - LEN_W'(1);
            if (last_rem) phase_q <= PH_STOP;
          end
          PH_STOP: phase_q <= PH_DONE;
          default: ;
        endcase
      end
      if (rd_fire) begin
        holding_q <= 1'b0;
        rem_q     <= rem_q - LEN_W'(1);
        if (last_rem) phase_q <= PH_STOP;
      end
      if (phase_q == PH_DONE) phase_q <= PH_IDLE;
    end
  end

  // R3
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_abort_evt |=> (eng_cmd_valid && eng_cmd_op == OP_STOP));

  // R4
  abort_no_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err) |-> (done_fails == '0));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_tvalid && !rd_tready) |=> (rd_tvalid && $stable(rd_tdata)));

  // R9
  fails_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_nack_evt |-> (fails_q < len_q));

  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_cmd_valid && !eng_cmd_ready) |=>
      (eng_cmd_valid && $stable(eng_cmd_op) && $stable(eng_cmd_byte)));

  // R11
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);

endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq
  import i2c_seq_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W = 16,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int ALEN_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [6:0]        req_chip,
  input  logic [ALEN_W-1:0] req_alen,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              cfg_rep_start,
  input  logic              cfg_fold_en,
  input  logic [6:0]        cfg_fold_mask,
  input  logic              wr_tvalid,
  output logic              wr_tready,
  input  logic [7:0]        wr_tdata,
  output logic              rd_tvalid,
  input  logic              rd_tready,
  output logic [7:0]        rd_tdata,
  output logic              eng_cmd_valid,
  input  logic              eng_cmd_ready,
  output logic [1:0]        eng_cmd_op,
  output logic [7:0]        eng_cmd_byte,
  output logic              eng_cmd_nack,
  input  logic              eng_rsp_valid,
  input  logic              eng_rsp_nack,
  input  logic [7:0]        eng_rsp_byte,
  output logic              done,
  output logic              done_err,
  output logic [LEN_W-1:0]  done_fails
);

  logic [6:0]        chip_f;
  logic              fold_on;
  logic [ADDR_W-1:0] addr_q;
  logic [ALEN_W-1:0] sub_idx;
  logic [7:0]        sub_byte;

  assign fold_on = cfg_fold_en && (req_kind != KIND_PROBE);

  i2c_seq_fold #(.ADDR_BYTES(ADDR_BYTES)) i_fold (
    .chip_i(req_chip), .addr_i(req_addr), .alen_i(req_alen),
    .mask_i(cfg_fold_mask), .en_i(fold_on), .chip_o(chip_f)
  );

  i2c_seq_subaddr #(.ADDR_BYTES(ADDR_BYTES)) i_subaddr (
    .addr_i(addr_q), .idx_i(sub_idx), .byte_o(sub_byte)
  );

  i2c_seq_ctrl #(.ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_chip_f(chip_f), .req_alen(req_alen), .req_addr(req_addr), .req_len(req_len),
    .cfg_rep_start(cfg_rep_start),
    .addr_q(addr_q), .sub_idx(sub_idx), .sub_byte(sub_byte),
    .wr_tvalid(wr_tvalid), .wr_tready(wr_tready), .wr_tdata(wr_tdata),
    .rd_tvalid(rd_tvalid), .rd_tready(rd_tready), .rd_tdata(rd_tdata),
    .eng_cmd_valid(eng_cmd_valid), .eng_cmd_ready(eng_cmd_ready),
    .eng_cmd_op(eng_cmd_op), .eng_cmd_byte(eng_cmd_byte), .eng_cmd_nack(eng_cmd_nack),
    .eng_rsp_valid(eng_rsp_valid), .eng_rsp_nack(eng_rsp_nack), .eng_rsp_byte(eng_rsp_byte),
    .done(done), .done_err(done_err), .done_fails(done_fails)
  );

  // R8
  fold_keeps_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> ((chip_f & req_chip) == req_chip));

  // R8
  fold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !fold_on) |-> (chip_f == req_chip));

endmodule

// File: tb/test_i2c_xact_seq.sv
module test_i2c_xact_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [6:0]  req_chip = '0;
  logic [2:0]  req_alen = '0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        cfg_rep_start = 1'b0;
  logic        cfg_fold_en = 1'b0;
  logic [6:0]  cfg_fold_mask = '0;
  logic        wr_tvalid, wr_tready;
  logic [7:0]  wr_tdata;
  logic        rd_tvalid, rd_tready;
  logic [7:0]  rd_tdata;
  logic        eng_cmd_valid, eng_cmd_ready, eng_cmd_nack;
  logic [1:0]  eng_cmd_op;
  logic [7:0]  eng_cmd_byte;
  logic        eng_rsp_valid = 1'b0, eng_rsp_nack = 1'b0;
  logic [7:0]  eng_rsp_byte = '0;
  logic        done, done_err;
  logic [15:0] done_fails;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_xact_seq i_i2c_xact_seq (.*);

  int n_tests = 0;
  int n_fail = 0;

  // Bench controls
  logic        clr = 1'b0;
  logic        rd_stall = 1'b0;
  logic [31:0] nack_mask = '0;
  int          wr_n = 0;
  logic [7:0]  wr_buf [16];
  int          cyc = 0;

  // Engine model and observers
  logic        pend = 1'b0;
  int          pcnt = 0;
  int          wr_cmd_idx = 0;
  int          rd_cnt_eng = 0;
  logic [10:0] log_q [64];
  int          log_n = 0;
  logic [7:0]  rd_got [16];
  int          rd_n = 0;
  int          wr_idx = 0;
  logic        done_seen = 1'b0;
  logic        got_err = 1'b0;
  logic [15:0] got_fails = '0;

  assign eng_cmd_ready = !pend;
  assign rd_tready = !rd_stall || cyc[0];
  assign wr_tvalid = (wr_idx < wr_n);
  assign wr_tdata  = wr_buf[wr_idx % 16];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    eng_rsp_valid <= 1'b0;
    if (clr) begin
      log_n <= 0; wr_cmd_idx <= 0; rd_cnt_eng <= 0; rd_n <= 0; wr_idx <= 0;
      done_seen <= 1'b0;
    end else begin
      if (eng_cmd_valid && eng_cmd_ready) begin
        if (log_n < 64)
          log_q[log_n] <= {eng_cmd_op, eng_cmd_nack,
                           (eng_cmd_op == 2'd2) ? eng_cmd_byte : 8'h00};
        log_n <= log_n + 1;
        pend <= 1'b1;
        pcnt <= 2;
        eng_rsp_nack <= (eng_cmd_op == 2'd2) ? nack_mask[wr_cmd_idx % 32] : 1'b0;
        eng_rsp_byte <= 8'hA0 + 8'(rd_cnt_eng);
        if (eng_cmd_op == 2'd2) wr_cmd_idx <= wr_cmd_idx + 1;
        if (eng_cmd_op == 2'd3) rd_cnt_eng <= rd_cnt_eng + 1;
      end else if (pend) begin
        if (pcnt == 1) begin pend <= 1'b0; eng_rsp_valid <= 1'b1; end
        pcnt <= pcnt - 1;
      end
      if (rd_tvalid && rd_tready) begin
        if (rd_n < 16) rd_got[rd_n] <= rd_tdata;
        rd_n <= rd_n + 1;
      end
      if (wr_tvalid && wr_tready) wr_idx <= wr_idx + 1;
      if (done) begin
        done_seen <= 1'b1; got_err <= done_err; got_fails <= done_fails;
      end
    end
  end

  // Expected command stream built from the requirements
  logic [10:0] exp_q [64];
  int          exp_n;
  logic        exp_err;
  int          exp_fails;
  int          exp_rd;

  function automatic void add(input int op, input bit nk, input logic [7:0] b);
    if (exp_n < 64) exp_q[exp_n] = {op[1:0], nk, b};
    exp_n++;
  endfunction

  function automatic void build_exp(input int kind, input logic [6:0] chip, input int alen,
                                    input logic [31:0] addr, input int len, input bit rep,
                                    input bit fold, input logic [6:0] mask,
                                    input logic [31:0] nm);
    int wi = 0;
    bit ok = 1;
    logic [63:0] wide;
    logic [6:0] cf;
    exp_n = 0; exp_err = 0; exp_fails = 0; exp_rd = 0;
    wide = {32'b0, addr} >> (8 * alen);
    cf = (fold && kind != 0) ? (chip | (wide[6:0] & mask)) : chip;
    add(0, 0, 8'h00);
    if (kind == 0) begin
      add(2, 0, {chip, 1'b0});
      exp_err = nm[0];
      add(1, 0, 8'h00);
      return;
    end
    if (kind != 1 || alen != 0) begin
      add(2, 0, {cf, 1'b0});
      if (nm[wi]) ok = 0;
      wi++;
      for (int b = alen - 1; b >= 0 && ok; b--) begin
        wide = {32'b0, addr} >> (8 * b);
        add(2, 0, wide[7:0]);
        if (nm[wi]) ok = 0;
        wi++;
      end
    end
    if (!ok) begin exp_err = 1; add(1, 0, 8'h00); return; end
    if (kind == 1) begin
      if (alen != 0) begin
        if (!rep) add(1, 0, 8'h00);
        add(0, 0, 8'h00);
      end
      add(2, 0, {cf, 1'b1});
      if (nm[wi]) begin exp_err = 1; add(1, 0, 8'h00); return; end
      for (int i = 0; i < len; i++) add(3, (i == len - 1), 8'h00);
      exp_rd = len;
      add(1, 0, 8'h00);
    end else begin
      for (int i = 0; i < len; i++) begin
        add(2, 0, 8'h30 + 8'(i));
        if (nm[wi]) exp_fails++;
        wi++;
      end
      add(1, 0, 8'h00);
    end
  endfunction

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int expv);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic run(input string req, input int kind, input logic [6:0] chip, input int alen,
                     input logic [31:0] addr, input int len, input bit rep, input bit fold,
                     input logic [6:0] mask, input logic [31:0] nm, input bit stall);
    int waitc = 0;
    int bad = -1;
    @(negedge clk);
    nack_mask = nm; rd_stall = stall; wr_n = len;
    for (int i = 0; i < 16; i++) wr_buf[i] = 8'h30 + 8'(i);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    req_kind = kind[1:0]; req_chip = chip; req_alen = alen[2:0]; req_addr = addr;
    req_len = len[15:0]; cfg_rep_start = rep; cfg_fold_en = fold; cfg_fold_mask = mask;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11", "req_ready while busy", int'(req_ready), 0);
    while (!done_seen && waitc < 3000) begin
      @(negedge clk);
      waitc++;
    end
    if (!done_seen) begin
      chk(1'b0, req, "watchdog: no done", waitc, 0);
      return;
    end
    build_exp(kind, chip, alen, addr, len, rep, fold, mask, nm);
    for (int i = exp_n - 1; i >= 0; i--) if (i < log_n && log_q[i] != exp_q[i]) bad = i;
    if (bad < 0 && log_n != exp_n) bad = (log_n < exp_n) ? log_n : exp_n;
    if (bad >= 0 && bad < 64)
      chk(1'b0, req, $sformatf("command %0d (count %0d vs %0d)", bad, log_n, exp_n),
          int'(log_q[bad]), int'(exp_q[bad]));
    else
      chk(1'b1, req, "command stream", 0, 0);
    chk(got_err == exp_err, req, "done_err", int'(got_err), int'(exp_err));
    chk(int'(got_fails) == exp_fails, req, "done_fails", int'(got_fails), exp_fails);
    chk(rd_n == exp_rd, req, "read byte count", rd_n, exp_rd);
    for (int i = 0; i < exp_rd && i < 16 && i < rd_n; i++)
      chk(rd_got[i] == 8'hA0 + 8'(i), req, $sformatf("read byte %0d", i),
          int'(rd_got[i]), int'(8'hA0 + 8'(i)));
  endtask

  // Scenario tasks
  task automatic t_reset;
    chk(req_ready == 1'b1, "R11", "reset req_ready", int'(req_ready), 1);
    chk(eng_cmd_valid == 1'b0, "R11", "reset eng_cmd_valid", int'(eng_cmd_valid), 0);
    chk(rd_tvalid == 1'b0, "R11", "reset rd_tvalid", int'(rd_tvalid), 0);
    chk(done == 1'b0, "R11", "reset done", int'(done), 0);
  endtask

  task automatic t_probe;
    run("R1", 0, 7'h50, 0, 0, 0, 0, 0, 0, 32'h0, 0);
    run("R1", 0, 7'h21, 2, 32'h1234, 0, 0, 1, 7'h7F, 32'h1, 0);
  endtask

  task automatic t_read_stop_start;
    run("R2", 1, 7'h51, 2, 32'h0000_1234, 3, 0, 0, 0, 32'h0, 1);
    run("R7", 1, 7'h52, 3, 32'h00AB_CDEF, 5, 0, 0, 0, 32'h0, 1);
  endtask

  task automatic t_read_rep_start;
    run("R5", 1, 7'h53, 1, 32'h7F, 1, 1, 0, 0, 32'h0, 0);
  endtask

  task automatic t_read_no_addr;
    run("R6", 1, 7'h54, 0, 32'h0, 2, 0, 0, 0, 32'h0, 0);
  endtask

  task automatic t_read_chip_nack;
    run("R3", 1, 7'h55, 2, 32'h0102, 2, 0, 0, 0, 32'h1, 0);
  endtask

  task automatic t_sub_nack;
    run("R4", 1, 7'h56, 3, 32'h00AB_CDEF, 2, 0, 0, 0, 32'h4, 0);
    run("R4", 2, 7'h57, 1, 32'h10, 3, 0, 0, 0, 32'h2, 0);
  endtask

  task automatic t_read_dir_nack;
    run("R10", 1, 7'h58, 1, 32'h20, 3, 1, 0, 0, 32'h4, 0);
  endtask

  task automatic t_write_fails;
    run("R9", 2, 7'h59, 2, 32'h0456, 4, 0, 0, 0, 32'h50, 0);
    run("R9", 2, 7'h5A, 0, 32'h0, 0, 0, 0, 0, 32'h0, 0);
  endtask

  task automatic t_fold;
    run("R8", 2, 7'h50, 1, 32'h345, 1, 0, 1, 7'h03, 32'h0, 0);
    run("R8", 2, 7'h50, 1, 32'h345, 1, 0, 0, 7'h03, 32'h0, 0);
    run("R8", 1, 7'h50, 0, 32'h2, 1, 0, 1, 7'h07, 32'h0, 0);
    run("R8", 1, 7'h50, 4, 32'hFFFF_FFFF, 1, 0, 1, 7'h7F, 32'h0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_probe();
    t_read_stop_start();
    t_read_rep_start();
    t_read_no_addr();
    t_read_chip_nack();
    t_sub_nack();
    t_read_dir_nack();
    t_write_fails();
    t_fold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule